// File: doc/BRIEF.md
# Presence-Detect Serial Memory Slave

This block is the bus-facing half of a small serial configuration memory. It sits on a two-wire I2C bus as a slave and holds 256 bytes that a host can write and read one byte at a time. It has an address pointer that advances by itself after each byte. The whole block runs on a fast system clock. The SCL and SDA lines are brought in through a synchronizer and then sampled. The block drives SDA only through an open-drain pull-down enable, so a high level on the bus always comes from the external pull-up. Storage is modelled as a register file that is cleared at reset.

Three strap inputs set the low bits of the slave address, so eight of these blocks can share one bus. A write-protect input locks the lower half of the array. While it is asserted, writes that land there are still acknowledged, but the data is thrown away. When a stop ends a write that carried data, the block starts an internal busy window. The window length is a parameter counted in system clocks. During it the block refuses its own address, which lets a host poll for completion.

Top module: `pdSlave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Bus traffic that is not preceded by a start gets no response: SDA is never pulled low. A stop always returns the block to idle.
- R2: The first byte after a start is the slave address. Bits 7..4 must be 1010, bits 3..1 must equal the strap inputs, and bit 0 selects read (1) or write (0). On a match the block pulls SDA low for the ninth clock. On any other value it leaves SDA released.
- R3: In a write transaction, the first byte after the address loads the word pointer. Each later byte is stored at the pointer. Every byte is acknowledged on the ninth clock.
- R4: The word pointer advances by one after each byte that is stored or sent, and it wraps from 255 to 0. A read that starts with only a read address (a current-address read) begins at the pointer left by the previous transfer.
- R5: In a read, the block sends the byte at the pointer most significant bit first, changing SDA only while SCL is low. If the master pulls SDA low on the ninth clock, the block sends the next byte.
- R6: If the master leaves SDA high on the ninth clock of a read, the block stops driving SDA. It does not drive SDA again until a new start.
- R7: While write-protect is high, bytes written to addresses 0..127 are acknowledged but not stored. Addresses 128..255 are written normally.
- R8: A stop that ends a write transaction in which at least one data byte was received starts a busy window of BUSY_CYCLES system clocks. During that window a matching slave address is not acknowledged. After the window the block acknowledges its address again.
- R9: After reset, SDA is released and every memory byte reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock line as seen by the block |
| sdaIn | input | 1 | Bus data line as seen by the block |
| strap | input | 3 | Strap inputs that give the low bits of the slave address |
| wp | input | 1 | Write-protect for the lower half of the array |
| sdaOe | output | 1 | Pull-down enable for SDA (1 drives the line low) |

## Verification
Almost every internal fault shows up on SDA within one byte of where it happens:
- A wrong bit count or a bad address compare moves or removes the ninth-clock acknowledge.
- A pointer that fails to advance or wrap returns bytes from the wrong place on the very next read.
- A protection check that leaks, or a busy window that is too short or too long, is visible as a changed read-back byte or as an acknowledge where none is expected.

The bench sweeps every strap setting against every address pattern. It fills and reads back the whole array, crosses both the wrap point and the protection boundary, and probes the busy window from both sides. The wrong data also shows up only in those later reads, so stored data is checked against a model kept in the bench.

// File: rtl/pdSlavePkg.sv
package pdSlavePkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DEVADDR,
    S_DEVACK,
    S_WORDADDR,
    S_WORDACK,
    S_WRDATA,
    S_WRACK,
    S_RDDATA,
    S_RDACK
  } pdState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // take one received bit
    logic loadPtr;    // received byte becomes the word pointer
    logic writeByte;  // store received byte, then advance pointer
    logic loadOut;    // fetch byte at pointer into transmit shifter
    logic shiftOut;   // present next transmit bit
    logic incPtr;     // advance pointer after a sent byte
  } pdStrobe_t;

endpackage

// File: rtl/pdSync.sv
module pdSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dPrev
);

  // an idle bus rests high, so the chain resets to ones
  logic [STAGES:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '1;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign dout  = pipe[STAGES-1];
  assign dPrev = pipe[STAGES];

endmodule

// File: rtl/pdCtrl.sv
module pdCtrl
  import pdSlavePkg::*;
#(
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         BUSY_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               sdaBit,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strap,
  output pdStrobe_t          strb,
  output logic               ackOe,
  output logic               txEn
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  pdState_e    state, stateN;
  logic [3:0]  bitCnt, bitCntN;
  logic        ackN, txN;
  logic        rwBit, rwN;
  logic        ackSeen, ackSeenN;
  logic        pending, pendN;
  logic        armBusy;
  logic [BUSY_W-1:0] busyCnt;
  logic        receiving, devHit;

  assign receiving = (state == S_DEVADDR) || (state == S_WORDADDR) || (state == S_WRDATA);
  assign devHit    = (rxByte[7:1] == {DEV_TYPE, strap}) && (busyCnt == '0);

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    ackN     = ackOe;
    txN      = txEn;
    rwN      = rwBit;
    ackSeenN = ackSeen;
    pendN    = pending;
    armBusy  = 1'b0;
    strb     = '0;

    if (stopDet) begin
      stateN  = S_IDLE;
      ackN    = 1'b0;
      txN     = 1'b0;
      armBusy = pending;
      pendN   = 1'b0;
    end else if (startDet) begin
      stateN  = S_DEVADDR;
      bitCntN = 4'd0;
      ackN    = 1'b0;
      txN     = 1'b0;
    end else begin
      if (sclRise) begin
        if (receiving && bitCnt < 4'd8) begin
          strb.shiftIn = 1'b1;
          bitCntN      = bitCnt + 4'd1;
        end
        if (state == S_RDACK) ackSeenN = !sdaBit;
      end
      if (sclFall) begin
        case (state)
          S_DEVADDR: begin
            if (bitCnt == 4'd8) begin
              if (devHit) begin
                ackN   = 1'b1;
                rwN    = rxByte[0];
                stateN = S_DEVACK;
              end else begin
                stateN = S_IDLE;
              end
            end
          end
          S_DEVACK: begin
            ackN    = 1'b0;
            bitCntN = 4'd0;
            if (rwBit) begin
              stateN       = S_RDDATA;
              txN          = 1'b1;
              strb.loadOut = 1'b1;
            end else begin
              stateN = S_WORDADDR;
            end
          end
          S_WORDADDR: begin
            if (bitCnt == 4'd8) begin
              strb.loadPtr = 1'b1;
              ackN         = 1'b1;
              stateN       = S_WORDACK;
            end
          end
          S_WORDACK: begin
            ackN    = 1'b0;
            bitCntN = 4'd0;
            stateN  = S_WRDATA;
          end
          S_WRDATA: begin
            if (bitCnt == 4'd8) begin
              strb.writeByte = 1'b1;
              ackN           = 1'b1;
              pendN          = 1'b1;
              stateN         = S_WRACK;
            end
          end
          S_WRACK: begin
            ackN    = 1'b0;
            bitCntN = 4'd0;
            stateN  = S_WRDATA;
          end
          S_RDDATA: begin
            if (bitCnt == 4'd7) begin
              txN         = 1'b0;
              strb.incPtr = 1'b1;
              ackSeenN    = 1'b0;
              stateN      = S_RDACK;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntN       = bitCnt + 4'd1;
            end
          end
          S_RDACK: begin
            if (ackSeen) begin
              stateN       = S_RDDATA;
              txN          = 1'b1;
              strb.loadOut = 1'b1;
              bitCntN      = 4'd0;
            end else begin
              stateN = S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= 4'd0;
      ackOe   <= 1'b0;
      txEn    <= 1'b0;
      rwBit   <= 1'b0;
      ackSeen <= 1'b0;
      pending <= 1'b0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitCntN;
      ackOe   <= ackN;
      txEn    <= txN;
      rwBit   <= rwN;
      ackSeen <= ackSeenN;
      pending <= pendN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busyCnt <= '0;
    else if (armBusy)         busyCnt <= BUSY_W'(BUSY_CYCLES);
    else if (busyCnt != '0)   busyCnt <= busyCnt - 1'b1;
  end

  // R8: an address byte completed inside the busy window draws no acknowledge
  a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0 && sclFall && state == S_DEVADDR && bitCnt == 4'd8) |=> !ackOe);

  // R2: an address acknowledge only follows a received byte matching type and straps
  a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackOe) && state == S_DEVACK) |-> ($past(rxByte[7:1]) == {DEV_TYPE, $past(strap)}));

  // R6: a missing master acknowledge leaves SDA released
  a_r6_release_on_nack: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RDACK && sclFall && !ackSeen && !startDet && !stopDet) |=> (!ackOe && !txEn));

  // R5: the transmitter is only active inside a read transaction
  a_r5_tx_in_read: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> rwBit);

endmodule

// File: rtl/pdData.sv
module pdData
  import pdSlavePkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  pdStrobe_t  strb,
  input  logic       sdaBit,
  input  logic       wp,
  output logic [7:0] rxByte,
  output logic       txBit
);

  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int LOCK_LIMIT = DEPTH / 2;

  logic [7:0]        memQ [DEPTH];
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rxShift;
  logic [7:0]        txShift;
  logic              locked;

  assign locked = wp && (int'(ptr) < LOCK_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= 8'hFF;
    else if (strb.loadOut)   txShift <= memQ[ptr];
    else if (strb.shiftOut)  txShift <= {txShift[6:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   ptr <= '0;
    else if (strb.loadPtr)                       ptr <= rxShift[ADDR_W-1:0];
    else if (strb.writeByte || strb.incPtr)      ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
    end else if (strb.writeByte && !locked) begin
      memQ[ptr] <= rxShift;
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];

  // R4: pointer wraps from the top address to zero
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.incPtr || strb.writeByte) && !strb.loadPtr && ptr == ADDR_W'(DEPTH - 1)) |=> (ptr == '0));

  // R7: a protected write leaves the addressed byte unchanged
  a_r7_locked_keep: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && wp && int'(ptr) < LOCK_LIMIT) |=> (memQ[$past(ptr)] == $past(memQ[ptr])));

endmodule

// File: rtl/pdSlave.sv
module pdSlave
  import pdSlavePkg::*;
#(
  parameter int         DEPTH       = 256,
  parameter int         STRAP_W     = 3,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         BUSY_CYCLES = 200,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scl,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wp,
  output logic               sdaOe
);

  logic [1:0] busNow, busPrev;
  logic       sclNow, sdaNow, sclPrev, sdaPrev;
  logic       sclRise, sclFall, startDet, stopDet;
  logic       ackOe, txEn, txBit;
  logic [7:0] rxByte;
  pdStrobe_t  strb;

  pdSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk   (clk),
    .rstN  (rstN),
    .din   ({scl, sdaIn}),
    .dout  (busNow),
    .dPrev (busPrev)
  );

  assign sclNow   = busNow[1];
  assign sdaNow   = busNow[0];
  assign sclPrev  = busPrev[1];
  assign sdaPrev  = busPrev[0];
  assign sclRise  = sclNow && !sclPrev;
  assign sclFall  = !sclNow && sclPrev;
  assign startDet = sclNow && sclPrev && sdaPrev && !sdaNow;
  assign stopDet  = sclNow && sclPrev && !sdaPrev && sdaNow;

  pdCtrl #(
    .STRAP_W     (STRAP_W),
    .DEV_TYPE    (DEV_TYPE),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaBit   (sdaNow),
    .rxByte   (rxByte),
    .strap    (strap),
    .strb     (strb),
    .ackOe    (ackOe),
    .txEn     (txEn)
  );

  pdData #(.DEPTH(DEPTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdaBit (sdaNow),
    .wp     (wp),
    .rxByte (rxByte),
    .txBit  (txBit)
  );

  assign sdaOe = ackOe || (txEn && !txBit);

  // R1: the slave moves SDA only while SCL is low, except when a start or stop aborts it
  a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclNow || $past(startDet || stopDet)));

endmodule

// File: tb/test_pdSlave.sv
module test_pdSlave;

  localparam int CLK_PERIOD = 10;
  localparam int HT         = 6;
  localparam int BUSY       = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strap = 3'd0;
  logic       wp = 1'b0;
  logic       sdaOe;
  logic       busSda;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [256];

  assign busSda = mSda && !sdaOe;

  always #(CLK_PERIOD / 2) clk = !clk;

  pdSlave i_pdSlave (
    .clk   (clk),
    .rstN  (rstN),
    .scl   (scl),
    .sdaIn (busSda),
    .strap (strap),
    .wp    (wp),
    .sdaOe (sdaOe)
  );

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busStart();
    waitC(1); mSda = 1'b1; waitC(HT); scl = 1'b1; waitC(HT);
    mSda = 1'b0; waitC(HT); scl = 1'b0;
  endtask

  task automatic busStop();
    waitC(1); mSda = 1'b0; waitC(HT); scl = 1'b1; waitC(HT);
    mSda = 1'b1; waitC(HT);
  endtask

  task automatic putByte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) begin
      waitC(1); mSda = b[i]; waitC(HT); scl = 1'b1; waitC(HT); scl = 1'b0;
    end
    waitC(1); mSda = 1'b1; waitC(HT); scl = 1'b1; waitC(HT / 2);
    ackd = !busSda;
    waitC(HT / 2); scl = 1'b0;
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitC(1); mSda = 1'b1; waitC(HT); scl = 1'b1; waitC(HT / 2);
      b[i] = busSda;
      waitC(HT / 2); scl = 1'b0;
    end
    waitC(1); mSda = !ackIt; waitC(HT); scl = 1'b1; waitC(HT); scl = 1'b0;
    waitC(1); mSda = 1'b1;
  endtask

  function automatic logic [7:0] devByte(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 91) & 255);
  endfunction

  // write address + word address, leaving pointer set; checks both acks
  task automatic setPtr(input logic [7:0] a, input string tag);
    logic ack;
    busStart();
    putByte(devByte(strap, 1'b0), ack); check({tag, " addr ack"}, int'(ack), 1);
    putByte(a, ack);                    check({tag, " word ack"}, int'(ack), 1);
  endtask

  // read n bytes from the current pointer after a (repeated) start
  task automatic readRun(input int first, input int n, input string tag);
    logic ack;
    logic [7:0] v;
    busStart();
    putByte(devByte(strap, 1'b1), ack); check({tag, " read addr ack"}, int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      getByte(k != n - 1, v);
      check($sformatf("%s byte@%0d", tag, (first + k) & 255), int'(v), int'(model[(first + k) & 255]));
    end
    busStop();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'd0;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    waitC(5);
    rstN = 1'b1;
    waitC(3);

    // R9: released after reset
    check("R9 sdaOe after reset", int'(sdaOe), 0);

    // R1: a matching address byte without a start is ignored
    strap = 3'd5;
    waitC(1); scl = 1'b0;
    putByte(devByte(3'd5, 1'b0), ack);
    check("R1 no ack without start", int'(ack), 0);
    busStop();

    // R9: memory reads zero after reset
    setPtr(8'd0, "R9");
    readRun(0, 3, "R9 zero");

    // R2: exhaustive strap versus address sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int a = 0; a < 8; a++) begin
        busStart();
        putByte(devByte(3'(a), 1'b0), ack);
        check($sformatf("R2 strap=%0d addr=%0d", s, a), int'(ack), int'(a == s));
        busStop();
      end
      busStart();
      putByte({4'b1011, 3'(s), 1'b0}, ack);
      check($sformatf("R2 wrong type strap=%0d", s), int'(ack), 0);
      busStop();
    end

    // R3: fill whole array in 32-byte writes; R8 probed after first block
    strap = 3'd2;
    for (int blk = 0; blk < 8; blk++) begin
      setPtr(8'(blk * 32), "R3");
      for (int k = 0; k < 32; k++) begin
        putByte(pat(blk * 32 + k), ack);
        check($sformatf("R3 data ack @%0d", blk * 32 + k), int'(ack), 1);
        model[blk * 32 + k] = pat(blk * 32 + k);
      end
      busStop();
      if (blk == 0) begin
        busStart();
        putByte(devByte(strap, 1'b0), ack);
        check("R8 nack during busy", int'(ack), 0);
        busStop();
        waitC(BUSY + 20);
        busStart();
        putByte(devByte(strap, 1'b0), ack);
        check("R8 ack after busy", int'(ack), 1);
        busStop();
      end else begin
        waitC(BUSY + 20);
      end
    end

    // R5: sequential read of the whole array
    setPtr(8'd0, "R5");
    readRun(0, 256, "R5 seq");

    // R4: pointer wrapped back to 0 after 256 bytes; current-address read
    readRun(0, 1, "R4 wrap current");

    // R4: read across the top of the array
    setPtr(8'd254, "R4");
    readRun(254, 4, "R4 wrap");

    // R4: pointer advances after each sent byte
    setPtr(8'd40, "R4");
    readRun(40, 2, "R4 inc");
    readRun(42, 1, "R4 current");

    // R6: after a master nack the slave leaves SDA alone
    setPtr(8'd10, "R6");
    busStart();
    putByte(devByte(strap, 1'b1), ack); check("R6 read addr ack", int'(ack), 1);
    getByte(1'b0, v);
    check("R6 byte before nack", int'(v), int'(model[10]));
    getByte(1'b0, v);
    check("R6 bus released after nack", int'(v), 255);
    busStop();

    // R7: protected writes across the half boundary
    wp = 1'b1;
    setPtr(8'd126, "R7");
    for (int k = 0; k < 4; k++) begin
      putByte(8'(8'hC1 + k), ack);
      check($sformatf("R7 ack @%0d", 126 + k), int'(ack), 1);
      if (126 + k >= 128) model[126 + k] = 8'(8'hC1 + k);
    end
    busStop();
    waitC(BUSY + 20);
    wp = 1'b0;
    setPtr(8'd126, "R7");
    readRun(126, 4, "R7 readback");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule